// File: doc/BRIEF.md
# Programmable Prescaled Interval Timer

A 32-bit up-counter with an 8-bit clock prescaler, a programmable terminal value and a sticky hit flag that can raise a level interrupt. Software runs it in one of two modes: a single pass from zero up to the terminal value that then stops, or a continuous mode that returns to zero after the terminal value and repeats. Each start clears both the count and the prescaler phase. The count advances once every `divide + 1` clock cycles.

All configuration goes through a byte-wide register bus. A write takes effect at the clock edge that samples it. A read strobe returns the addressed byte on `bus_rdata` one cycle later. The live count is exposed as four bytes. Reading the lowest byte also copies the whole count into a shadow register, and the three upper count bytes return that copy, so a four-byte read always gives one consistent value.

Register map (byte addresses):
- 0x0: mode. Bit 0 starts continuous mode and bit 1 starts single-pass mode. Both read back.
- 0x1: interrupt mask. Bit 0 is the enable.
- 0x2: status. Bit 0 is the hit flag, which is cleared by writing 1.
- 0x4 to 0x7: terminal value, least significant byte at 0x4.
- 0x8 to 0xB: count, least significant byte at 0x8.
- 0xC: divide value.

Top module: `interval_timer`

## Requirements
- R1: After reset the mode, mask, status, count and divide bytes read 0x00, and all four terminal bytes read 0xFF. `irq` is low.
- R2: In continuous mode, a read of count byte 0x8 sampled `k` cycles after the start edge returns `floor((k-1)/(D+1)) mod (L+1)`, where D is the divide value and L is the terminal value.
- R3: In single-pass mode, the count follows `min(floor((k-1)/(D+1)), L)`. After reaching L it holds L, and mode bit 1 clears by itself, so the mode byte reads 0x00.
- R4: A write to 0x0 with bit 1 set selects single-pass mode, even if bit 0 is also set. Bit 0 alone selects continuous mode, and each mode cancels the other. Unused bits of the mode and mask bytes read 0, and unmapped addresses read 0x00.
- R5: The hit flag sets at the edge where the running count, sitting at L, receives its next prescaler tick, which is `(L+1)*(D+1)` edges after the start. It stays set until it is cleared.
- R6: Writing status with bit 0 = 1 clears the hit flag. Writing status with bit 0 = 0 leaves the flag unchanged.
- R7: Any write to the mode byte, and any write to any terminal byte, clears the hit flag.
- R8: `irq` is high exactly while the hit flag and mask bit 0 are both 1.
- R9: Starting either mode clears the count and the prescaler phase, whatever count the timer held before.
- R10: A read of 0x8 returns the live low byte and captures all 32 bits. Reads of 0x9 to 0xB return bytes of that capture until the next read of 0x8.
- R11: Writing 0x00 to the mode byte stops counting. The count keeps the value it reached at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 4 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Level interrupt (hit AND mask) |

## Verification
The bench sweeps small terminal and divide values in both modes. It reads the low count byte on every cycle, so a prescaler phase that is off by one, or a wrong wrap value, shows up as a wrong byte within one divide period of the fault. A hit flag that sets or clears in the wrong cycle appears on `irq` in the same cycle and on the status byte on the next read. A torn or stale capture only becomes visible once the live count has carried into byte 1. For that reason the capture test lets the count run past 256 between the two reads.

// File: rtl/interval_timer_pkg.sv
package interval_timer_pkg;

  localparam int ADDR_W = 4;
  localparam int BYTE_W = 8;

  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t A_MODE = 4'h0;
  localparam addr_t A_MASK = 4'h1;
  localparam addr_t A_STAT = 4'h2;
  localparam addr_t A_LIM0 = 4'h4;
  localparam addr_t A_CNT0 = 4'h8;
  localparam addr_t A_DIV  = 4'hC;

  // bit positions match the mode byte: bit0 continuous, bit1 single pass
  typedef enum logic [1:0] {
    MODE_IDLE = 2'b00,
    MODE_LOOP = 2'b01,
    MODE_ONCE = 2'b10
  } mode_e;

  // single pass wins when both request bits are written
  function automatic mode_e decode_mode(input logic [BYTE_W-1:0] d);
    if (d[1])      return MODE_ONCE;
    else if (d[0]) return MODE_LOOP;
    else           return MODE_IDLE;
  endfunction

  function automatic logic [BYTE_W-1:0] mode_image(input mode_e m);
    return {{(BYTE_W-2){1'b0}}, m};
  endfunction

endpackage

// File: rtl/itmr_prescaler.sv
module itmr_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] phase_q;

  // ">=" keeps a phase that overshoots a freshly lowered divide from
  // running all the way around the counter
  function automatic logic phase_done(input logic [DIV_W-1:0] ph,
                                      input logic [DIV_W-1:0] lim);
    return ph >= lim;
  endfunction

  function automatic logic [DIV_W-1:0] phase_next(input logic [DIV_W-1:0] ph,
                                                  input logic [DIV_W-1:0] lim);
    return phase_done(ph, lim) ? '0 : ph + DIV_W'(1);
  endfunction

  assign tick = run && !restart && phase_done(phase_q, div);

  always_ff @(posedge clk) begin
    if (rst)          phase_q <= '0;
    else if (restart) phase_q <= '0;
    else if (run)     phase_q <= phase_next(phase_q, div);
  end

endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             loop,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap_evt
);

  logic [CNT_W-1:0] cnt_q;

  // at the terminal value: back to zero when continuous, hold when single pass
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                  input logic [CNT_W-1:0] lim,
                                                  input logic             lp);
    if (cur == lim) return lp ? '0 : cur;
    else            return cur + CNT_W'(1);
  endfunction

  assign wrap_evt = tick && (cnt_q == limit);
  assign cnt      = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (tick)    cnt_q <= next_count(cnt_q, limit, loop);
  end

endmodule

// File: rtl/itmr_regfile.sv
module itmr_regfile
  import interval_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_data,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              wrap_evt,
  output logic [CNT_W-1:0]  limit,
  output logic [DIV_W-1:0]  div,
  output logic              loop,
  output logic              once,
  output logic              ien,
  output logic              hit,
  output logic              start,
  output logic              cfg_clr,
  output logic              w1c
);

  localparam int LANES = CNT_W / BYTE_W;

  mode_e             mode_q;
  logic              ien_q;
  logic              hit_q;
  logic [DIV_W-1:0]  div_q;
  logic [CNT_W-1:0]  shadow_q;
  logic [BYTE_W-1:0] lim_byte_q [LANES];
  logic [LANES-1:0]  lim_wr;
  logic              wr_mode;
  logic              wr_mask;
  logic              wr_div;
  logic              snap;
  logic [BYTE_W-1:0] rd_mux;

  function automatic logic [BYTE_W-1:0] lane_of(input logic [CNT_W-1:0] w,
                                                input int k);
    return w[k*BYTE_W +: BYTE_W];
  endfunction

  assign wr_mode = wr_en && (addr == A_MODE);
  assign wr_mask = wr_en && (addr == A_MASK);
  assign wr_div  = wr_en && (addr == A_DIV);
  assign w1c     = wr_en && (addr == A_STAT) && wr_data[0];
  assign start   = wr_mode && (wr_data[1:0] != 2'b00);
  assign cfg_clr = wr_mode || (|lim_wr);
  assign snap    = rd_en && (addr == A_CNT0);

  for (genvar g = 0; g < LANES; g++) begin : g_lim
    localparam addr_t LANE_ADDR = A_LIM0 + ADDR_W'(g);
    assign lim_wr[g] = wr_en && (addr == LANE_ADDR);
    assign limit[g*BYTE_W +: BYTE_W] = lim_byte_q[g];
    always_ff @(posedge clk) begin
      if (rst)            lim_byte_q[g] <= '1;
      else if (lim_wr[g]) lim_byte_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                mode_q <= MODE_IDLE;
    else if (wr_mode)                       mode_q <= decode_mode(wr_data);
    else if (wrap_evt && mode_q == MODE_ONCE) mode_q <= MODE_IDLE;
  end

  // reconfiguration beats a new hit; a new hit beats a software clear
  always_ff @(posedge clk) begin
    if (rst)           hit_q <= 1'b0;
    else if (cfg_clr)  hit_q <= 1'b0;
    else if (wrap_evt) hit_q <= 1'b1;
    else if (w1c)      hit_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q <= 1'b0;
      div_q <= '0;
    end else begin
      if (wr_mask) ien_q <= wr_data[0];
      if (wr_div)  div_q <= wr_data[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       shadow_q <= '0;
    else if (snap) shadow_q <= cnt;
  end

  always_comb begin
    rd_mux = '0;
    if (addr == A_MODE) rd_mux = mode_image(mode_q);
    if (addr == A_MASK) rd_mux = {{(BYTE_W-1){1'b0}}, ien_q};
    if (addr == A_STAT) rd_mux = {{(BYTE_W-1){1'b0}}, hit_q};
    if (addr == A_DIV)  rd_mux = BYTE_W'(div_q);
    for (int k = 0; k < LANES; k++) begin
      if (addr == A_LIM0 + ADDR_W'(k)) rd_mux = lim_byte_q[k];
      if (addr == A_CNT0 + ADDR_W'(k)) rd_mux = (k == 0) ? lane_of(cnt, 0) : lane_of(shadow_q, k);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  assign div  = div_q;
  assign loop = (mode_q == MODE_LOOP);
  assign once = (mode_q == MODE_ONCE);
  assign ien  = ien_q;
  assign hit  = hit_q;

endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import interval_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq
);

  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] limit_w;
  logic [DIV_W-1:0] div_w;
  logic             tick_w;
  logic             wrap_evt_w;
  logic             loop_w;
  logic             once_w;
  logic             run_w;
  logic             ien_w;
  logic             hit_w;
  logic             start_w;
  logic             cfg_clr_w;
  logic             w1c_w;

  assign run_w = loop_w || once_w;

  itmr_regfile #(.CNT_W(CNT_W), .DIV_W(DIV_W)) regs_i (
    .clk      (clk),
    .rst      (rst),
    .addr     (bus_addr),
    .wr_en    (bus_wr),
    .wr_data  (bus_wdata),
    .rd_en    (bus_rd),
    .rd_data  (bus_rdata),
    .cnt      (cnt_w),
    .wrap_evt (wrap_evt_w),
    .limit    (limit_w),
    .div      (div_w),
    .loop     (loop_w),
    .once     (once_w),
    .ien      (ien_w),
    .hit      (hit_w),
    .start    (start_w),
    .cfg_clr  (cfg_clr_w),
    .w1c      (w1c_w)
  );

  itmr_prescaler #(.DIV_W(DIV_W)) presc_i (
    .clk     (clk),
    .rst     (rst),
    .run     (run_w),
    .restart (start_w),
    .div     (div_w),
    .tick    (tick_w)
  );

  itmr_counter #(.CNT_W(CNT_W)) count_i (
    .clk      (clk),
    .rst      (rst),
    .restart  (start_w),
    .loop     (loop_w),
    .tick     (tick_w),
    .limit    (limit_w),
    .cnt      (cnt_w),
    .wrap_evt (wrap_evt_w)
  );

  assign irq = hit_w && ien_w;

endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             wrap_evt,
  input logic             start,
  input logic             cfg_clr,
  input logic             w1c,
  input logic             hit,
  input logic             ien,
  input logic             irq,
  input logic             loop,
  input logic             once,
  input logic [CNT_W-1:0] cnt
);

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && !wrap_evt) |=> (cnt == $past(cnt) + CNT_W'(1)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !start) |=> $stable(cnt));

  assert_loop_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (wrap_evt && loop) |=> (cnt == '0));

  assert_once_stop_R3: assert property (@(posedge clk) disable iff (rst)
    (wrap_evt && once && !cfg_clr) |=> (!once && $stable(cnt)));

  assert_hit_source_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(hit) |-> $past(wrap_evt));

  assert_w1c_R6: assert property (@(posedge clk) disable iff (rst)
    (w1c && !wrap_evt) |=> !hit);

  assert_cfg_clear_R7: assert property (@(posedge clk) disable iff (rst)
    cfg_clr |=> !hit);

  assert_irq_level_R8: assert property (@(posedge clk) disable iff (rst)
    (irq && !w1c && !cfg_clr) |=> (irq || !ien));

  assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
    start |=> (cnt == '0));

endmodule

bind interval_timer interval_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick_w),
  .wrap_evt (wrap_evt_w),
  .start    (start_w),
  .cfg_clr  (cfg_clr_w),
  .w1c      (w1c_w),
  .hit      (hit_w),
  .ien      (ien_w),
  .irq      (irq),
  .loop     (loop_w),
  .once     (once_w),
  .cnt      (cnt_w)
);

// File: tb/interval_timer_tb_top.sv
`timescale 1ns/1ps
module interval_timer_tb_top;

  localparam logic [3:0] R_MODE = 4'h0;
  localparam logic [3:0] R_MASK = 4'h1;
  localparam logic [3:0] R_STAT = 4'h2;
  localparam logic [3:0] R_LIM0 = 4'h4;
  localparam logic [3:0] R_CNT0 = 4'h8;
  localparam logic [3:0] R_DIV  = 4'hC;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       irq;

  int cyc = 0;
  int vectors = 0;
  int misses = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  interval_timer dut_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the sampling edge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_limit(input logic [31:0] v);
    for (int k = 0; k < 4; k++) wr(R_LIM0 + 4'(k), 8'(v >> (8*k)));
  endtask

  task automatic run_cfg(input int lim, input int dv, input bit single, input bit ie);
    int s;
    int n;
    logic [7:0] d;
    wr(R_DIV, 8'(dv));
    set_limit(32'(lim));
    wr(R_MASK, {7'b0, ie});
    wr(R_MODE, single ? 8'h02 : 8'h01);
    s = cyc;
    n = (lim + 2) * (dv + 1) + 2;
    bus_addr = R_CNT0; bus_rd = 1'b1;
    for (int j = 0; j < n; j++) begin
      int e;
      int t;
      int ec;
      bit eh;
      @(negedge clk);
      e = cyc;
      t = (e - s - 1) / (dv + 1);
      ec = single ? ((t > lim) ? lim : t) : (t % (lim + 1));
      if (j == 0) check("R9", "count after start", 32'(bus_rdata), 32'h0);
      else check(single ? "R3" : "R2", "count byte", 32'(bus_rdata), 32'(ec & 8'hFF));
      eh = ((e - s) / (dv + 1)) >= (lim + 1);
      check(ie ? "R5" : "R8", "irq", 32'(irq), 32'(eh & ie));
    end
    bus_rd = 1'b0;
    rd(R_STAT, d);
    check("R5", "hit after run", 32'(d), 32'h1);
    if (single) begin
      rd(R_MODE, d);
      check("R3", "mode after single pass", 32'(d), 32'h0);
    end
  endtask

  task automatic finish_once();
    wr(R_DIV, 8'h00);
    set_limit(32'd2);
    wr(R_MASK, 8'h01);
    wr(R_MODE, 8'h02);
    repeat (8) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    int s;
    int e0;
    int e1;
    int w;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset values
    check("R1", "irq", 32'(irq), 32'h0);
    rd(R_MODE, d); check("R1", "mode", 32'(d), 32'h00);
    rd(R_MASK, d); check("R1", "mask", 32'(d), 32'h00);
    rd(R_STAT, d); check("R1", "status", 32'(d), 32'h00);
    rd(R_DIV, d);  check("R1", "divide", 32'(d), 32'h00);
    for (int k = 0; k < 4; k++) begin
      rd(R_LIM0 + 4'(k), d); check("R1", "limit byte", 32'(d), 32'hFF);
      rd(R_CNT0 + 4'(k), d); check("R1", "count byte", 32'(d), 32'h00);
    end

    // R4 mode priority, reserved bits, unmapped address
    wr(R_MASK, 8'hFF); rd(R_MASK, d); check("R4", "mask reserved", 32'(d), 32'h01);
    wr(R_MASK, 8'h00);
    wr(R_MODE, 8'hFF); rd(R_MODE, d); check("R4", "both bits", 32'(d), 32'h02);
    wr(R_MODE, 8'h01); rd(R_MODE, d); check("R4", "continuous", 32'(d), 32'h01);
    wr(R_MODE, 8'h02); rd(R_MODE, d); check("R4", "single", 32'(d), 32'h02);
    wr(R_MODE, 8'h00); rd(R_MODE, d); check("R4", "idle", 32'(d), 32'h00);
    rd(4'h3, d); check("R4", "unmapped", 32'(d), 32'h00);

    // R2 R3 R5 R8 R9 sweep
    for (int sgl = 0; sgl < 2; sgl++)
      for (int dv = 0; dv < 4; dv++)
        for (int lim = 0; lim < 5; lim++)
          run_cfg(lim, dv, sgl[0], dv[0]);

    // R6 R7 R8 hit clearing
    finish_once();
    rd(R_STAT, d); check("R5", "hit set", 32'(d), 32'h1);
    wr(R_STAT, 8'h00); rd(R_STAT, d); check("R6", "write 0 keeps hit", 32'(d), 32'h1);
    check("R8", "irq with hit", 32'(irq), 32'h1);
    wr(R_MASK, 8'h00); check("R8", "masked irq", 32'(irq), 32'h0);
    wr(R_MASK, 8'h01); check("R8", "unmasked irq", 32'(irq), 32'h1);
    wr(R_STAT, 8'h01); rd(R_STAT, d); check("R6", "write 1 clears", 32'(d), 32'h0);
    check("R8", "irq after clear", 32'(irq), 32'h0);
    finish_once();
    wr(R_LIM0 + 4'd3, 8'h00); rd(R_STAT, d); check("R7", "top limit byte write", 32'(d), 32'h0);
    finish_once();
    wr(R_LIM0, 8'h02); rd(R_STAT, d); check("R7", "low limit byte write", 32'(d), 32'h0);
    finish_once();
    wr(R_MODE, 8'h00); rd(R_STAT, d); check("R7", "mode write", 32'(d), 32'h0);
    check("R8", "irq after mode write", 32'(irq), 32'h0);

    // R10 capture, R11 stop
    wr(R_DIV, 8'h00);
    set_limit(32'hFFFF_FFFF);
    wr(R_MODE, 8'h01);
    s = cyc;
    repeat (3) @(negedge clk);
    rd(R_CNT0, d); e0 = cyc;
    check("R10", "low byte live", 32'(d), 32'((e0 - s - 1) & 8'hFF));
    repeat (300) @(negedge clk);
    rd(R_CNT0 + 4'd1, d); check("R10", "byte1 from capture", 32'(d), 32'(((e0 - s - 1) >> 8) & 8'hFF));
    rd(R_CNT0 + 4'd2, d); check("R10", "byte2 from capture", 32'(d), 32'h0);
    rd(R_CNT0 + 4'd3, d); check("R10", "byte3 from capture", 32'(d), 32'h0);
    rd(R_CNT0, d); e1 = cyc;
    check("R10", "low byte recapture", 32'(d), 32'((e1 - s - 1) & 8'hFF));
    rd(R_CNT0 + 4'd1, d); check("R10", "byte1 recapture", 32'(d), 32'(((e1 - s - 1) >> 8) & 8'hFF));
    wr(R_MODE, 8'h00); w = cyc;
    repeat (20) @(negedge clk);
    rd(R_CNT0, d); check("R11", "held low byte", 32'(d), 32'((w - s) & 8'hFF));
    rd(R_CNT0 + 4'd1, d); check("R11", "held byte1", 32'(d), 32'(((w - s) >> 8) & 8'hFF));
    repeat (10) @(negedge clk);
    rd(R_CNT0, d); check("R11", "still held", 32'(d), 32'((w - s) & 8'hFF));

    summary();
    $finish;
  end

endmodule